// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits beside an asynchronous SRAM port whose accesses have already been brought into the local clock domain. Each access arrives as a one-cycle strobe with an address, a write flag and a chip-select. The block looks for one particular run of six consecutive reads. The first five reads must go to fixed key addresses. The sixth address picks one of four non-volatile commands: store, recall, auto-store off, or auto-store on. When the run is recognised, the block raises exactly one command output for one cycle. The reads themselves go to the array as usual; this block only watches them.

Matching looks at address bits 14..2 only. A write, or a read of an address that does not fit the run, ends the attempt. If that read is itself the first key, it starts a new attempt. A store or recall holds the I/O lock from the cycle after the sixth access until the sequencer reports that the operation is done. Auto-store on/off changes only a volatile setting, which is brought out as a level. Keeping that setting over a power cycle is the job of a later store, which is done elsewhere.

States: `ST_IDLE` (no progress), `ST_K1`..`ST_K5` (that many keys matched), `ST_LOCK` (store/recall in progress). Transitions:
- *advance*: the next key is read.
- *restart*: a non-fitting read of the first key, which goes to `ST_K1`.
- *abort*: a write, a non-fitting read, or an inhibit, which goes to `ST_IDLE`.
- *fire-setting*: `ST_K5` goes to `ST_IDLE` on auto-store on/off.
- *fire-lock*: `ST_K5` goes to `ST_LOCK` on store/recall.
- *release*: `ST_LOCK` goes to `ST_IDLE` on `op_done`.

Top module: `rsc_cmd_detect`

## Requirements
- R1: After reset there is no progress, all four command outputs are 0, `io_lock` is 0, and `as_enable` equals the parameter `AS_RESET`.
- R2: The five lead reads must hit keys 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order. The sixth read then selects the command: 0x8FC0 gives store, 0x4C63 gives recall, 0x8B45 gives auto-store off, and 0x4B46 gives auto-store on. The pulse is visible in the cycle after the clock edge that samples the sixth read. Cycles with no access between the reads do not break the run.
- R3: Only address bits 14..2 are compared. Bits 1..0 and bits 15 and up never change the result.
- R4: An access with `acc_write`=1 aborts the run at any step, and no command follows from that attempt.
- R5: A read whose address does not fit the current step aborts the run. If that read matches the first key, it counts as step one of a new attempt.
- R6: A read counts when `acc_ce_strb` or `acc_oe_strb` is high with `acc_sel`=1. Both strobes in one cycle count as a single access. A strobe with `acc_sel`=0 is ignored.
- R7: Each command output is high for one cycle only, and at most one command output is high in any cycle.
- R8: Store and recall raise `io_lock` together with their pulse. `io_lock` stays high until the first cycle after an edge that samples `op_done`=1. Accesses made while locked are ignored.
- R9: Auto-store off clears `as_enable` and auto-store on sets it, both in the same cycle as the pulse. Store and recall leave it unchanged.
- R10: `seq_inhibit`=1 outside the lock clears progress, and an access in the same cycle is ignored.
- R11: A sixth read that is not one of the four command keys issues no command; the rule of R5 applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_ce_strb | input | 1 | Access strobe timed by chip enable |
| acc_oe_strb | input | 1 | Access strobe timed by output enable |
| acc_sel | input | 1 | Chip selected during the strobe |
| acc_write | input | 1 | 1 marks the access as a write |
| acc_addr | input | ADDR_W | Access address |
| seq_inhibit | input | 1 | Sequencer access inhibit, clears progress |
| op_done | input | 1 | Store/recall finished, releases the lock |
| cmd_store | output | 1 | Store command pulse |
| cmd_recall | output | 1 | Recall command pulse |
| cmd_as_off | output | 1 | Auto-store disable pulse |
| cmd_as_on | output | 1 | Auto-store enable pulse |
| io_lock | output | 1 | I/O locked during store/recall |
| as_enable | output | 1 | Volatile auto-store setting |

## Verification
The bench builds the block with `ADDR_W`=18 and `AS_RESET`=0. The narrower address still leaves bits 15..17 above the compared field, so random don't-care bits reach both sides of the key window. Starting with auto-store off means the first auto-store on command produces a visible change of `as_enable` rather than a silent no-op. Random streams are biased toward the next expected key, which reaches deep steps, restarts on the first key, sixth-step misses, inhibits and lock releases far more often than uniform addresses would.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int KEY_HI = 14;
    localparam int KEY_LO = 2;
    localparam int KEY_W  = KEY_HI - KEY_LO + 1;
    localparam int N_LEAD = 5;
    localparam int N_CMD  = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_K3   = 3'd3,
        ST_K4   = 3'd4,
        ST_K5   = 3'd5,
        ST_LOCK = 3'd6
    } seq_state_e;

    typedef enum logic [2:0] {
        FIRE_NONE   = 3'd0,
        FIRE_STORE  = 3'd1,
        FIRE_RECALL = 3'd2,
        FIRE_AS_OFF = 3'd3,
        FIRE_AS_ON  = 3'd4
    } fire_e;

    function automatic logic [KEY_W-1:0] key_of(input logic [15:0] a);
        return a[KEY_HI:KEY_LO];
    endfunction

    // Lead keys, in the order they must be read.
    function automatic logic [15:0] lead_addr(input int unsigned i);
        case (i)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction

    // Sixth-step keys; the index maps to FIRE_STORE + index.
    function automatic logic [15:0] cmd_addr(input int unsigned i);
        case (i)
            0:       return 16'h8FC0;
            1:       return 16'h4C63;
            2:       return 16'h8B45;
            default: return 16'h4B46;
        endcase
    endfunction

endpackage

// File: rtl/rsc_access_qual.sv
module rsc_access_qual
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              ce_strb,
    input  logic              oe_strb,
    input  logic              sel,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_ev,
    output logic              wr_ev,
    output logic [KEY_W-1:0]  key
);

    logic any_strb;
    logic unused_addr_bits;

    always_comb begin
        any_strb = (ce_strb | oe_strb) & sel;
        rd_ev    = any_strb & ~write;
        wr_ev    = any_strb & write;
        key      = addr[KEY_HI:KEY_LO];
    end

    assign unused_addr_bits = ^{addr[ADDR_W-1:KEY_HI+1], addr[KEY_LO-1:0]};

endmodule

// File: rtl/rsc_key_match.sv
module rsc_key_match
    import rsc_pkg::*;
(
    input  logic [KEY_W-1:0]  key,
    output logic [N_LEAD-1:0] lead_hit,
    output logic [N_CMD-1:0]  cmd_hit
);

    for (genvar g = 0; g < N_LEAD; g++) begin : g_lead
        assign lead_hit[g] = (key == key_of(lead_addr(g)));
    end

    for (genvar g = 0; g < N_CMD; g++) begin : g_cmd
        assign cmd_hit[g] = (key == key_of(cmd_addr(g)));
    end

endmodule

// File: rtl/rsc_seq_fsm.sv
module rsc_seq_fsm
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ev,
    input  logic              wr_ev,
    input  logic              inhibit,
    input  logic              op_done,
    input  logic [N_LEAD-1:0] lead_hit,
    input  logic [N_CMD-1:0]  cmd_hit,
    output seq_state_e        state,
    output fire_e             fire
);

    seq_state_e nxt;
    logic       step_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        fire = FIRE_NONE;
        if (state == ST_K5 && rd_ev && !inhibit) begin
            if      (cmd_hit[0]) fire = FIRE_STORE;
            else if (cmd_hit[1]) fire = FIRE_RECALL;
            else if (cmd_hit[2]) fire = FIRE_AS_OFF;
            else if (cmd_hit[3]) fire = FIRE_AS_ON;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:        step_ok = lead_hit[0];
            ST_K1:          step_ok = lead_hit[1];
            ST_K2:          step_ok = lead_hit[2];
            ST_K3:          step_ok = lead_hit[3];
            ST_K4:          step_ok = lead_hit[4];
            ST_K5, ST_LOCK: step_ok = 1'b0;
            default:        step_ok = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOCK: begin
                if (op_done) nxt = ST_IDLE;
            end
            ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4, ST_K5: begin
                if (inhibit || wr_ev) begin
                    nxt = ST_IDLE;
                end else if (rd_ev) begin
                    if (fire == FIRE_STORE || fire == FIRE_RECALL) nxt = ST_LOCK;
                    else if (fire != FIRE_NONE)                    nxt = ST_IDLE;
                    else if (step_ok)                              nxt = seq_state_e'(state + 3'd1);
                    else if (lead_hit[0])                          nxt = ST_K1;
                    else                                           nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assert_inhibit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && state != ST_LOCK) |=> state == ST_IDLE);

    assert_write_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev && state != ST_LOCK) |=> state == ST_IDLE);

    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !op_done) |=> state == ST_LOCK);

    assert_lock_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && op_done) |=> state == ST_IDLE);

endmodule

// File: rtl/rsc_cmd_unit.sv
module rsc_cmd_unit
    import rsc_pkg::*;
#(
    parameter bit AS_RESET = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  fire_e fire,
    output logic  cmd_store,
    output logic  cmd_recall,
    output logic  cmd_as_off,
    output logic  cmd_as_on,
    output logic  as_enable
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_store  <= 1'b0;
            cmd_recall <= 1'b0;
            cmd_as_off <= 1'b0;
            cmd_as_on  <= 1'b0;
            as_enable  <= AS_RESET;
        end else begin
            cmd_store  <= (fire == FIRE_STORE);
            cmd_recall <= (fire == FIRE_RECALL);
            cmd_as_off <= (fire == FIRE_AS_OFF);
            cmd_as_on  <= (fire == FIRE_AS_ON);
            if (fire == FIRE_AS_OFF)     as_enable <= 1'b0;
            else if (fire == FIRE_AS_ON) as_enable <= 1'b1;
        end
    end

    assert_one_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_store, cmd_recall, cmd_as_off, cmd_as_on}));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_store || cmd_recall || cmd_as_off || cmd_as_on)
        |=> !(cmd_store || cmd_recall || cmd_as_off || cmd_as_on));

    assert_as_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_as_off |-> !as_enable);

    assert_as_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_as_on |-> as_enable);

    assert_as_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_store || cmd_recall) |-> $stable(as_enable));

endmodule

// File: rtl/rsc_cmd_detect.sv
module rsc_cmd_detect
    import rsc_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter bit AS_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_ce_strb,
    input  logic              acc_oe_strb,
    input  logic              acc_sel,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              seq_inhibit,
    input  logic              op_done,
    output logic              cmd_store,
    output logic              cmd_recall,
    output logic              cmd_as_off,
    output logic              cmd_as_on,
    output logic              io_lock,
    output logic              as_enable
);

    logic              rd_ev;
    logic              wr_ev;
    logic [KEY_W-1:0]  key;
    logic [N_LEAD-1:0] lead_hit;
    logic [N_CMD-1:0]  cmd_hit;
    seq_state_e        fsm_state;
    fire_e             fire;

    rsc_access_qual #(.ADDR_W(ADDR_W)) u_qual (
        .ce_strb (acc_ce_strb),
        .oe_strb (acc_oe_strb),
        .sel     (acc_sel),
        .write   (acc_write),
        .addr    (acc_addr),
        .rd_ev   (rd_ev),
        .wr_ev   (wr_ev),
        .key     (key)
    );

    rsc_key_match u_match (
        .key      (key),
        .lead_hit (lead_hit),
        .cmd_hit  (cmd_hit)
    );

    rsc_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_ev    (rd_ev),
        .wr_ev    (wr_ev),
        .inhibit  (seq_inhibit),
        .op_done  (op_done),
        .lead_hit (lead_hit),
        .cmd_hit  (cmd_hit),
        .state    (fsm_state),
        .fire     (fire)
    );

    rsc_cmd_unit #(.AS_RESET(AS_RESET)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .cmd_store  (cmd_store),
        .cmd_recall (cmd_recall),
        .cmd_as_off (cmd_as_off),
        .cmd_as_on  (cmd_as_on),
        .as_enable  (as_enable)
    );

    assign io_lock = (fsm_state == ST_LOCK);

    assert_cmd_after_k5_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_store || cmd_recall || cmd_as_off || cmd_as_on) |-> $past(fsm_state == ST_K5));

    assert_lock_with_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_store || cmd_recall) |-> io_lock);

    assert_no_cmd_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(io_lock) |-> !(cmd_store || cmd_recall || cmd_as_off || cmd_as_on));

endmodule

// File: tb/rsc_cmd_detect_bench.sv
`timescale 1ns/1ps
module rsc_cmd_detect_bench;

    localparam int AW  = 18;
    localparam bit ASR = 1'b0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_ce_strb = 1'b0, acc_oe_strb = 1'b0, acc_sel = 1'b0, acc_write = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          seq_inhibit = 1'b0, op_done = 1'b0;
    logic          cmd_store, cmd_recall, cmd_as_off, cmd_as_on, io_lock, as_enable;

    always #2 clk = ~clk;

    rsc_cmd_detect #(.ADDR_W(AW), .AS_RESET(ASR)) u_rsc_cmd_detect (
        .clk(clk), .rst_n(rst_n),
        .acc_ce_strb(acc_ce_strb), .acc_oe_strb(acc_oe_strb), .acc_sel(acc_sel),
        .acc_write(acc_write), .acc_addr(acc_addr),
        .seq_inhibit(seq_inhibit), .op_done(op_done),
        .cmd_store(cmd_store), .cmd_recall(cmd_recall), .cmd_as_off(cmd_as_off),
        .cmd_as_on(cmd_as_on), .io_lock(io_lock), .as_enable(as_enable)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model: progress 0..5, 6 = locked.
    int   ms = 0;
    logic e_st = 0, e_rc = 0, e_off = 0, e_on = 0, e_asen = ASR;

    localparam logic [15:0] K_STORE = 16'h8FC0, K_RECALL = 16'h4C63,
                            K_OFF = 16'h8B45, K_ON = 16'h4B46;

    function automatic logic [15:0] lead(input int i);
        case (i)
            0: return 16'h4E38; 1: return 16'hB1C7; 2: return 16'h83E0;
            3: return 16'h7C1F; default: return 16'h703F;
        endcase
    endfunction

    function automatic bit same(input logic [31:0] a, input logic [15:0] k);
        return ((a >> 2) & 32'h1FFF) == ((32'(k) >> 2) & 32'h1FFF);
    endfunction

    // Randomise every bit outside 14..2 (R3).
    function automatic logic [31:0] dc(input logic [31:0] a);
        logic [31:0] m;
        m = ((32'd1 << AW) - 1) & ~32'h7FFC;
        return (a & ~m) | ($urandom & m);
    endfunction

    task automatic mdl(input bit ce, oe, sel, wr, input logic [31:0] a, input bit inh, done);
        bit acc;
        acc = (ce | oe) & sel;
        e_st = 0; e_rc = 0; e_off = 0; e_on = 0;
        if (ms == 6) begin
            if (done) ms = 0;
        end else if (inh) begin
            ms = 0;
        end else if (acc) begin
            if (wr) ms = 0;
            else if (ms < 5 && same(a, lead(ms))) ms = ms + 1;
            else if (ms == 5 && same(a, K_STORE))  begin e_st = 1; ms = 6; end
            else if (ms == 5 && same(a, K_RECALL)) begin e_rc = 1; ms = 6; end
            else if (ms == 5 && same(a, K_OFF))    begin e_off = 1; e_asen = 0; ms = 0; end
            else if (ms == 5 && same(a, K_ON))     begin e_on = 1; e_asen = 1; ms = 0; end
            else ms = same(a, lead(0)) ? 1 : 0;
        end
    endtask

    task automatic check(input string tag);
        logic [5:0] got, exp;
        got = {cmd_store, cmd_recall, cmd_as_off, cmd_as_on, io_lock, as_enable};
        exp = {e_st, e_rc, e_off, e_on, (ms == 6), e_asen};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {store,recall,off,on,lock,asen} got %b expected %b at %0t",
                     tag, got, exp, $time);
        end
    endtask

    task automatic step(input bit ce, oe, sel, wr, input logic [31:0] a,
                        input bit inh, done, input string tag);
        acc_ce_strb = ce; acc_oe_strb = oe; acc_sel = sel; acc_write = wr;
        acc_addr = a[AW-1:0]; seq_inhibit = inh; op_done = done;
        mdl(ce, oe, sel, wr, a, inh, done);
        @(negedge clk);
        check(tag);
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        step(1, 0, 1, 0, a, 0, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic leads(input int n, input string tag);
        for (int i = 0; i < n; i++) rd(lead(i), tag);
    endtask

    task automatic release_lock(input string tag);
        idle(tag);
        step(0, 0, 0, 0, 0, 0, 1, tag);
        idle(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");

        leads(5, "R2 store lead"); rd(K_STORE, "R2 store fires / R8 lock");
        idle("R8 lock held");
        leads(5, "R8 reads ignored while locked"); rd(K_RECALL, "R8 no cmd while locked");
        release_lock("R8 release");

        leads(5, "R2 recall lead"); rd(K_RECALL, "R2 recall fires / R9 asen kept");
        release_lock("R8 release after recall");

        leads(5, "R9 on lead"); rd(K_ON, "R9 as-on sets as_enable");
        idle("R7 pulse ends");
        leads(5, "R9 off lead"); rd(K_OFF, "R9 as-off clears as_enable");
        leads(5, "R9 on again"); rd(K_ON, "R9 as-on again");

        for (int i = 0; i < 5; i++) rd(dc(lead(i)), "R3 dont-care bits");
        rd(dc(K_STORE), "R3 store with dont-care bits");
        release_lock("R3 release");

        leads(3, "R4 before write");
        step(1, 0, 1, 1, lead(3), 0, 0, "R4 write aborts");
        rd(lead(3), "R4 after write"); rd(lead(4), "R4 after write");
        rd(K_STORE, "R4 no command");

        leads(3, "R5 before mismatch"); rd(32'h1234, "R5 mismatch");
        rd(lead(3), "R5 continue"); rd(lead(4), "R5 continue"); rd(K_OFF, "R5 no command");
        leads(3, "R5 restart prefix"); rd(lead(0), "R5 first key restarts");
        for (int i = 1; i < 5; i++) rd(lead(i), "R5 restarted run");
        rd(K_OFF, "R5 restart fires as-off");

        for (int i = 0; i < 5; i++) step(0, 1, 1, 0, lead(i), 0, 0, "R6 oe strobe");
        step(0, 1, 1, 0, K_ON, 0, 0, "R6 oe strobe fires");
        for (int i = 0; i < 5; i++) begin
            step(1, 1, 1, 0, lead(i), 0, 0, "R6 both strobes count once");
            step(1, 0, 0, 0, 32'h0ABC, 0, 0, "R6 deselected ignored");
            idle("R2 idle gap");
        end
        step(1, 1, 1, 0, K_OFF, 0, 0, "R6 fires as-off");

        leads(3, "R10 before inhibit");
        step(1, 0, 1, 0, lead(3), 1, 0, "R10 inhibit clears");
        rd(lead(4), "R10 after inhibit"); rd(K_STORE, "R10 no command");

        leads(5, "R11 lead"); rd(32'h1111, "R11 bad sixth");
        leads(5, "R11 lead"); rd(lead(0), "R11 sixth restarts");
        for (int i = 1; i < 5; i++) rd(lead(i), "R11 continue");
        rd(K_ON, "R11 fires after restart");

        for (int n = 0; n < 6000; n++) begin
            int r, kind;
            logic [31:0] a;
            bit sel, wr, inh, done;
            r = int'($urandom % 100);
            if (r < 60) a = (ms < 5) ? 32'(lead(ms)) :
                            32'(($urandom % 2) ? (($urandom % 2) ? K_STORE : K_RECALL)
                                               : (($urandom % 2) ? K_OFF : K_ON));
            else if (r < 72) a = 32'(lead(int'($urandom % 5)));
            else a = $urandom;
            a = dc(a);
            kind = int'($urandom % 4);
            sel  = ($urandom % 10) != 0;
            wr   = ($urandom % 25) == 0;
            inh  = ($urandom % 60) == 0;
            done = (ms == 6) ? (($urandom % 6) == 0) : (($urandom % 30) == 0);
            step(kind == 1 || kind == 3, kind == 2 || kind == 3, sel, wr, a, inh, done,
                 "R2/R5/R7 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule